// File: doc/BRIEF.md
# Four-Level Line Code Half-Pulse Shaper

This block turns a stream of two-bit line symbols into an oversampled pulse-density code for a five-level transmit D/A converter. Each symbol is shaped as a symmetric pulse that lasts two symbol periods. Only the rising half of that pulse is kept, as a one-bit density sequence of 96 samples. The falling half is produced by reading the same sequence from its far end back towards its start.

In every symbol period, the symbol now being sent reads the table forward to form its rising half. The symbol sent one period earlier reads the table backward to form its falling half. Each half adds -1, 0 or +1 to a sample, so their sum lies between -2 and +2. A register holds that sum for the converter.

The sample clock enable runs at 7.68 MHz, which gives 80 kHz symbols with 96 samples each. A framing strobe can realign the symbol boundary. A transmit enable mutes the output.

Top module: `quat_pulse_shaper`

## Requirements
- R1: A sample index steps by one on every clock with `smp_en` high. It wraps from 95 back to 0, and that wrap is a symbol boundary.
- R2: `baud_stb` high together with `smp_en` is a symbol boundary whatever the index is, and the index restarts at 0 on the next sample.
- R3: At every symbol boundary the current symbol loads `dibit`, and the previous symbol takes the value the current symbol held until then.
- R4: Symbol encoding: bit 1 is the sign (1 = negative) and bit 0 is the magnitude (1 = outer level ±3 with the large table, 0 = inner level ±1 with the small table). A half's contribution is its table bit, negated when the sign is set.
- R5: At index n the current symbol reads its table at address n. The previous symbol reads its table at address 95−n.
- R6: Table bit at address a equals floor(C(a)/256) − floor(C(a−1)/256). Here C(a) is the sum over i = 0..a of floor((i+1)·A/96), and C(−1) = 0. A is 240 for the outer table and 80 for the inner table.
- R7: On each clock with `smp_en` high, `pdm_code` registers the sum of both contributions as 3-bit two's complement. The sum uses the index and symbols held before that edge, and it always lies in −2..+2.
- R8: `pdm_code` holds its value on clocks where `smp_en` is low.
- R9: After reset `pdm_code` is 0 and the index is 0. Both symbols count as zero amplitude until loaded, so the previous half stays 0 until the second boundary.
- R10: With `tx_en` low on a sampled clock, both contributions are zero and `pdm_code` registers 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_en | input | 1 | Sample clock enable (7.68 MHz rate) |
| baud_stb | input | 1 | Framing strobe that forces a symbol boundary |
| dibit | input | 2 | Next symbol: bit 1 sign, bit 0 magnitude |
| tx_en | input | 1 | Transmit enable; low mutes both halves |
| pdm_code | output | 3 | Five-level code, two's complement −2..+2 |

## Verification
The bench sends symbols that change on every clock, so a design that latches `dibit` anywhere except a boundary produces the wrong pulse at once. Sampling gaps and framing strobes at random indices expose a counter that skips on a held clock or ignores a restart; either fault shifts every later sample. Held symbols of each of the four values check that sign and magnitude were not swapped. Sample 95 is compared against address 0 of the backward read, so an off-by-one in the mirrored address shows up. The first symbol after reset is compared with a silent previous half, which catches a design that counts its reset state as a real symbol.

// File: rtl/pshp_pkg.sv
package pshp_pkg;

  typedef struct packed {
    logic neg;    // 1 = negative level
    logic outer;  // 1 = outer level (large table)
  } sym_t;

  // Target density at address i is floor((i+1)*amp/samples) out of 256.
  // The bit is the carry of the running sum across a multiple of 256.
  function automatic logic density_bit(int amp, int samples, int addr);
    int cum_now;
    int cum_old;
    cum_now = 0;
    cum_old = 0;
    for (int i = 0; i <= addr; i++) begin
      cum_old = cum_now;
      cum_now = cum_now + ((i + 1) * amp) / samples;
    end
    return ((cum_now / 256) - (cum_old / 256)) != 0;
  endfunction

  // Signed contribution of one pulse half: -1, 0 or +1.
  function automatic logic signed [1:0] half_value(logic tbl_bit, logic neg,
                                                   logic live);
    if (!live || !tbl_bit) return 2'sd0;
    return neg ? -2'sd1 : 2'sd1;
  endfunction

endpackage

// File: rtl/pshp_phase.sv
module pshp_phase #(
  parameter int SAMPLES = 96,
  localparam int PW = $clog2(SAMPLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_en,
  input  logic          baud_stb,
  output logic [PW-1:0] phase,
  output logic          boundary
);
  localparam logic [PW-1:0] LAST = PW'(SAMPLES - 1);

  assign boundary = smp_en && (baud_stb || phase == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase <= '0;
    else if (boundary) phase <= '0;
    else if (smp_en)   phase <= phase + 1'b1;
  end
endmodule

// File: rtl/pshp_symbols.sv
module pshp_symbols
  import pshp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boundary,
  input  logic [1:0] dibit,
  output sym_t       cur_sym,
  output logic       cur_vld,
  output sym_t       prev_sym,
  output logic       prev_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_sym  <= '0;
      cur_vld  <= 1'b0;
      prev_sym <= '0;
      prev_vld <= 1'b0;
    end else if (boundary) begin
      cur_sym  <= sym_t'(dibit);
      cur_vld  <= 1'b1;
      prev_sym <= cur_sym;
      prev_vld <= cur_vld;
    end
  end
endmodule

// File: rtl/pshp_half.sv
module pshp_half
  import pshp_pkg::*;
#(
  parameter int SAMPLES = 96,
  parameter int AMP_OUTER = 240,
  parameter int AMP_INNER = 80,
  parameter bit MIRROR = 1'b0,
  localparam int PW = $clog2(SAMPLES)
) (
  input  logic [PW-1:0]      phase,
  input  sym_t               sym,
  input  logic               live,
  input  logic               tx_en,
  output logic signed [1:0]  contrib
);
  localparam logic [PW-1:0] LAST = PW'(SAMPLES - 1);

  logic [SAMPLES-1:0] tbl_outer;
  logic [SAMPLES-1:0] tbl_inner;

  for (genvar a = 0; a < SAMPLES; a++) begin : g_rom
    assign tbl_outer[a] = density_bit(AMP_OUTER, SAMPLES, a);
    assign tbl_inner[a] = density_bit(AMP_INNER, SAMPLES, a);
  end

  logic [PW-1:0] addr;
  logic          tbl_bit;

  if (MIRROR) begin : g_back
    assign addr = LAST - phase;
  end else begin : g_front
    assign addr = phase;
  end

  assign tbl_bit = sym.outer ? tbl_outer[addr] : tbl_inner[addr];
  assign contrib = half_value(tbl_bit, sym.neg, live && tx_en);
endmodule

// File: rtl/quat_pulse_shaper.sv
module quat_pulse_shaper
  import pshp_pkg::*;
#(
  parameter int SAMPLES = 96,
  parameter int AMP_OUTER = 240,
  parameter int AMP_INNER = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_en,
  input  logic       baud_stb,
  input  logic [1:0] dibit,
  input  logic       tx_en,
  output logic [2:0] pdm_code
);
  localparam int PW = $clog2(SAMPLES);

  logic [PW-1:0]     phase;
  logic              boundary;
  sym_t              cur_sym;
  sym_t              prev_sym;
  logic              cur_vld;
  logic              prev_vld;
  logic signed [1:0] front_c;
  logic signed [1:0] back_c;
  logic signed [2:0] sum_c;
  logic signed [2:0] code_q;

  pshp_phase #(.SAMPLES(SAMPLES)) u_phase (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .baud_stb(baud_stb),
    .phase(phase), .boundary(boundary)
  );

  pshp_symbols u_syms (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .dibit(dibit),
    .cur_sym(cur_sym), .cur_vld(cur_vld),
    .prev_sym(prev_sym), .prev_vld(prev_vld)
  );

  pshp_half #(.SAMPLES(SAMPLES), .AMP_OUTER(AMP_OUTER),
              .AMP_INNER(AMP_INNER), .MIRROR(1'b0)) u_front (
    .phase(phase), .sym(cur_sym), .live(cur_vld), .tx_en(tx_en),
    .contrib(front_c)
  );

  pshp_half #(.SAMPLES(SAMPLES), .AMP_OUTER(AMP_OUTER),
              .AMP_INNER(AMP_INNER), .MIRROR(1'b1)) u_back (
    .phase(phase), .sym(prev_sym), .live(prev_vld), .tx_en(tx_en),
    .contrib(back_c)
  );

  assign sum_c = {front_c[1], front_c} + {back_c[1], back_c};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (smp_en) code_q <= sum_c;
  end

  assign pdm_code = code_q;
endmodule

// File: rtl/quat_pulse_shaper_chk.sv
module quat_pulse_shaper_chk #(
  parameter int SAMPLES = 96,
  localparam int PW = $clog2(SAMPLES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_en,
  input logic          baud_stb,
  input logic          tx_en,
  input logic [PW-1:0] phase,
  input logic          boundary,
  input logic [1:0]    cur_sym,
  input logic          cur_vld,
  input logic [1:0]    prev_sym,
  input logic          prev_vld,
  input logic [2:0]    pdm_code
);
  // R1: index stays inside one symbol period
  p_phase_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PW'(SAMPLES));

  // R1: index wraps to zero after the last sample
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && phase == PW'(SAMPLES - 1)) |=> phase == '0);

  // R2: framing strobe restarts the index
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && baud_stb) |=> phase == '0);

  // R3: previous symbol follows the old current symbol
  p_prev_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (prev_sym == $past(cur_sym) && prev_vld == $past(cur_vld)));

  // R3: symbols do not move between boundaries
  p_sym_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(cur_sym) && $stable(prev_sym)));

  // R7: output within the five legal levels
  p_code_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(pdm_code) >= -3'sd2 && $signed(pdm_code) <= 3'sd2));

  // R8: output holds while the sample enable is low
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(pdm_code));

  // R10: muted samples register zero
  p_mute_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && !tx_en) |=> pdm_code == 3'd0);
endmodule

bind quat_pulse_shaper quat_pulse_shaper_chk #(.SAMPLES(SAMPLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .baud_stb(baud_stb),
  .tx_en(tx_en), .phase(phase), .boundary(boundary),
  .cur_sym(cur_sym), .cur_vld(cur_vld), .prev_sym(prev_sym),
  .prev_vld(prev_vld), .pdm_code(pdm_code)
);

// File: tb/quat_pulse_shaper_bench.sv
`timescale 1ns/1ps
module quat_pulse_shaper_bench;
  localparam int N = 96;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_en = 1'b0;
  logic       baud_stb = 1'b0;
  logic [1:0] dibit = 2'b00;
  logic       tx_en = 1'b1;
  logic [2:0] pdm_code;

  always #4 clk = ~clk;  // 125 MHz

  quat_pulse_shaper u_quat_pulse_shaper (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .baud_stb(baud_stb),
    .dibit(dibit), .tx_en(tx_en), .pdm_code(pdm_code)
  );

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;
  string ctx = "R9";

  // reference tables built by a running carry accumulator (R6)
  int tab_out[N];
  int tab_in[N];

  // behavioural model state
  int m_phase = 0;
  int m_cur = 0, m_cvld = 0, m_prev = 0, m_pvld = 0;
  int m_code = 0;

  function automatic int half(int sym, int vld, int addr);
    int b;
    if (vld == 0) return 0;
    b = sym[0] ? tab_out[addr] : tab_in[addr];     // R4 magnitude
    return sym[1] ? -b : b;                         // R4 sign
  endfunction

  task automatic build_tables();
    int acc_o = 0, acc_i = 0;
    for (int i = 0; i < N; i++) begin
      acc_o += ((i + 1) * 240) / N;
      acc_i += ((i + 1) * 80) / N;
      tab_out[i] = 0; tab_in[i] = 0;
      if (acc_o >= 256) begin tab_out[i] = 1; acc_o -= 256; end
      if (acc_i >= 256) begin tab_in[i] = 1; acc_i -= 256; end
    end
  endtask

  task automatic check(string tag);
    int got;
    got = int'($signed(pdm_code));
    vectors++;
    if (got !== m_code) begin
      errors++;
      $display("FAIL %s: pdm_code=%0d expected %0d (index %0d)",
               tag, got, m_code, m_phase);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit se, bit bs, logic [1:0] db, bit te);
    bit bnd;
    smp_en = se; baud_stb = bs; dibit = db; tx_en = te;
    @(posedge clk);
    if (se) begin
      // R5, R7: sum of forward and mirrored reads using pre-edge state
      m_code = te ? half(m_cur, m_cvld, m_phase) +
                    half(m_prev, m_pvld, N - 1 - m_phase) : 0;   // R10
      bnd = bs || (m_phase == N - 1);                // R1, R2
      if (bnd) begin
        m_prev = m_cur; m_pvld = m_cvld;             // R3
        m_cur = int'(db); m_cvld = 1;
        m_phase = 0;
      end else m_phase++;
    end
    @(negedge clk);
    check(ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    build_tables();
    repeat (3) @(negedge clk);
    ctx = "R9";
    check(ctx);                       // R9: zero output in reset
    rst_n = 1'b1;
    @(negedge clk);
    check(ctx);                       // R9: still zero before any sample
    // R9: first symbol period, previous half must stay silent
    for (int i = 0; i < 2 * N; i++) step(1, 0, 2'($urandom), 1);

    ctx = "R1";                       // free-running index, busy dibit bus
    for (int i = 0; i < 300; i++) step(1, 0, 2'($urandom), 1);

    ctx = "R8";                       // gaps in the sample enable
    for (int i = 0; i < 400; i++) step(($urandom % 2) == 0, 0, 2'($urandom), 1);

    ctx = "R2";                       // framing strobes at random indices
    for (int i = 0; i < 600; i++)
      step(($urandom % 5) != 0, ($urandom % 40) == 0, 2'($urandom), 1);

    ctx = "R10";                      // transmit muting
    for (int i = 0; i < 400; i++) step(1, 0, 2'($urandom), ($urandom % 3) != 0);

    ctx = "R4";                       // each level held for whole periods
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 2 * N; i++) step(1, 0, 2'(s), 1);

    ctx = "R3";                       // alternating opposite levels
    for (int i = 0; i < 6 * N; i++) step(1, 0, ((i / N) % 2) ? 2'b11 : 2'b01, 1);

    ctx = "R5 R6 R7";                 // long mixed run
    for (int i = 0; i < 3000; i++)
      step(($urandom % 8) != 0, ($urandom % 150) == 0, 2'($urandom),
           ($urandom % 50) != 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule